// File: doc/BRIEF.md
# Chip-Select Started Two-Byte Serial Word Sender

This block hands a 16-bit result to a remote receiver over a single serial line that can be tri-stated. The line carries ordinary asynchronous character frames. An externally supplied serial clock sets the bit rate, and each clock period carries one bit. The receiver, or its host, asks for each character by pulling chip select low. The word goes out as two separate frames. The first frame carries the upper byte and the second carries the lower byte. Between the two frames the line floats.

A data-valid strobe loads new words into a holding register. Words arrive much faster than a character takes to send, so the register is protected in two cases: while a frame is on the line, and while chip select is still held low after a frame. A word that arrives in either case is dropped. If chip select is raised after the upper byte, a fresh word can replace the register. The byte pointer then returns to the upper byte, and the next frame sends the upper byte of the new word.

Everything runs on the falling edge of the serial clock, which is the block's only clock.

Top module: `cs_uart_tx`

## Requirements
- R1: A synchronous reset (rst_n low at a falling edge of sclk) sets the following: sdata_oe = 0, sdata = 1, drdy = 0, and the byte pointer on the upper byte.
- R2: A frame starts only at a falling edge where the block is idle and cs_n is sampled low. sdata_oe rises on that same edge and stays high for the whole frame. With cs_n high, sdata_oe stays 0.
- R3: A frame is 11 bits, and each bit is held for one sclk period. Bit 0 is the start bit (0). Bits 1 to 8 are the data byte, least significant bit first. Bits 9 and 10 are stop bits (1).
- R4: After a word is loaded, the first frame carries word[15:8] and the next frame carries word[7:0]. After the lower byte, the pointer returns to the upper byte.
- R5: On the falling edge after the last stop bit, sdata_oe drops to 0 (high impedance) and sdata rests at 1.
- R6: After a frame ends, a new frame needs cs_n to be sampled high and then low. While cs_n is held low, no further frame starts.
- R7: A word_vld strobe is accepted only at a falling edge where no frame is being sent, chip select has been released since the last frame, and cs_n is high. Any other strobe is ignored and the register keeps its word.
- R8: An accepted word moves the byte pointer to the upper byte, even if only the upper byte of the previous word had been sent.
- R9: drdy is set when a word is accepted. It stays set through the upper-byte frame and clears at the end of the lower-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | External serial clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; low requests one frame |
| word_in | input | 16 | Word offered for loading |
| word_vld | input | 1 | Strobe: word_in is valid at this falling edge |
| sdata | output | 1 | Serial data, valid while sdata_oe is high |
| sdata_oe | output | 1 | Output enable of the serial line; 0 means high impedance |
| drdy | output | 1 | A loaded word has not yet been fully sent |

## Verification
The assertions assume that cs_n, word_vld and word_in are synchronous to sclk and settle before each falling edge, so every input is sampled exactly once per bit. They also assume cs_n and word_vld are 0 or 1, never unknown, once reset ends. The bench meets these conditions by changing inputs only just after the rising edge of sclk, half a period away from the sampling edge. It also drives every input to a known level before it releases reset.

// File: rtl/cs_uart_pkg.sv
`timescale 1ns/1ps
// Shared types for the chip-select started serial word sender.
// Assumes: nothing beyond IEEE 1800-2017.
package cs_uart_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // line floating, chip select released
        ST_SEND = 2'd1,   // a frame is on the line
        ST_HOLD = 2'd2    // frame finished, waiting for chip select release
    } tx_state_t;

endpackage

// File: rtl/cs_uart_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer. Starts a frame when cs_n is seen low in idle, counts the
// frame bits, and then waits for cs_n to be released before it re-arms.
// Assumes: cs_n is synchronous to the falling edge of sclk.
module cs_uart_frame_ctrl
    import cs_uart_pkg::*;
#(
    parameter int FRAME_LEN = 11
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    output logic start,
    output logic done,
    output logic sending,
    output logic idle
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

    tx_state_t        state_q;
    logic [CNT_W-1:0] bit_cnt_q;

    // Decode the state into start and end events and status flags
    always_comb begin
        idle    = (state_q == ST_IDLE);
        sending = (state_q == ST_SEND);
        start   = idle && !cs_n;
        done    = sending && (bit_cnt_q == LAST_BIT);
    end

    // Advance the state and the bit counter on each falling edge
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!cs_n) begin
                        state_q   <= ST_SEND;
                        bit_cnt_q <= '0;
                    end
                end
                ST_SEND: begin
                    if (bit_cnt_q == LAST_BIT) begin
                        state_q <= ST_HOLD;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cs_n) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cs_uart_word_reg.sv
`timescale 1ns/1ps
// Word holding register with byte pointer and ready flag. A new word is
// taken only when the sequencer is idle and chip select is high.
// Assumes: DATA_W is even; the upper half goes out first.
module cs_uart_word_reg #(
    parameter int DATA_W = 16
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                idle,
    input  logic                done,
    input  logic [DATA_W-1:0]   word_in,
    input  logic                word_vld,
    output logic [DATA_W/2-1:0] tx_byte,
    output logic                drdy
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] word_q;
    logic              lower_sel_q;
    logic              accept;

    // Select the byte for the next frame and decide whether to take a word
    always_comb begin
        accept  = word_vld && idle && cs_n;
        tx_byte = lower_sel_q ? word_q[BYTE_W-1:0] : word_q[DATA_W-1:BYTE_W];
    end

    // Load words, step the byte pointer, and track the ready flag
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            word_q      <= '0;
            lower_sel_q <= 1'b0;
            drdy        <= 1'b0;
        end else if (accept) begin
            word_q      <= word_in;
            lower_sel_q <= 1'b0;
            drdy        <= 1'b1;
        end else if (done) begin
            if (lower_sel_q) begin
                drdy <= 1'b0;
            end
            lower_sel_q <= !lower_sel_q;
        end
    end
endmodule

// File: rtl/cs_uart_shifter.sv
`timescale 1ns/1ps
// Frame shifter. It loads start bit, data byte (LSB first) and stop bits
// on start, then shifts one bit per falling edge, filling with ones.
// Assumes: start and sending come from the frame sequencer.
module cs_uart_shifter #(
    parameter int BYTE_W    = 8,
    parameter int STOP_BITS = 2
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sending,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sdata
);
    localparam int SHIFT_W = 1 + BYTE_W + STOP_BITS;

    logic [SHIFT_W-1:0] shreg_q;

    // Hold the line high when it is not driving a frame
    always_comb begin
        sdata = sending ? shreg_q[0] : 1'b1;
    end

    // Load the frame image or shift it out
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            shreg_q <= '1;
        end else if (start) begin
            shreg_q <= {{STOP_BITS{1'b1}}, tx_byte, 1'b0};
        end else if (sending) begin
            shreg_q <= {1'b1, shreg_q[SHIFT_W-1:1]};
        end
    end
endmodule

// File: rtl/cs_uart_tx.sv
`timescale 1ns/1ps
// Chip-select started serial sender for a two-byte word. Each low chip
// select sends one asynchronous frame. The upper byte goes first, and the
// line floats between frames.
// Assumes: all inputs are synchronous to the falling edge of sclk.
module cs_uart_tx #(
    parameter int DATA_W    = 16,
    parameter int STOP_BITS = 2
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] word_in,
    input  logic              word_vld,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              drdy
);
    localparam int BYTE_W    = DATA_W / 2;
    localparam int FRAME_LEN = 1 + BYTE_W + STOP_BITS;

    logic              start;
    logic              done;
    logic              sending;
    logic              idle;
    logic [BYTE_W-1:0] tx_byte;

    cs_uart_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .start   (start),
        .done    (done),
        .sending (sending),
        .idle    (idle)
    );

    cs_uart_word_reg #(.DATA_W(DATA_W)) u_word (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .idle     (idle),
        .done     (done),
        .word_in  (word_in),
        .word_vld (word_vld),
        .tx_byte  (tx_byte),
        .drdy     (drdy)
    );

    cs_uart_shifter #(.BYTE_W(BYTE_W), .STOP_BITS(STOP_BITS)) u_shift (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .start   (start),
        .sending (sending),
        .tx_byte (tx_byte),
        .sdata   (sdata)
    );

    // The output enable follows the frame-in-progress state
    always_comb begin
        sdata_oe = sending;
    end
endmodule

// File: rtl/cs_uart_tx_chk.sv
`timescale 1ns/1ps
// Protocol checker for cs_uart_tx, attached through bind.
// Assumes: inputs are known and synchronous to the falling edge of sclk.
module cs_uart_tx_chk #(
    parameter int FRAME_LEN = 11
) (
    input logic sclk,
    input logic rst_n,
    input logic cs_n,
    input logic word_vld,
    input logic sdata,
    input logic sdata_oe,
    input logic drdy
);
    logic [7:0] oe_run_q;

    // Count how many edges in a row the output enable has been high
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            oe_run_q <= '0;
        end else if (sdata_oe) begin
            oe_run_q <= oe_run_q + 1'b1;
        end else begin
            oe_run_q <= '0;
        end
    end

    AST_START_ON_CS: assert property (@(negedge sclk) disable iff (!rst_n)
        $rose(sdata_oe) |-> ($past(cs_n) == 1'b0) && (sdata == 1'b0)); // R2

    AST_FRAME_LENGTH: assert property (@(negedge sclk) disable iff (!rst_n)
        $fell(sdata_oe) |-> (oe_run_q == 8'(FRAME_LEN))); // R3

    AST_STOP_BITS_HIGH: assert property (@(negedge sclk) disable iff (!rst_n)
        $fell(sdata_oe) |-> $past(sdata) && $past(sdata, 2)); // R3

    AST_IDLE_LINE_HIGH: assert property (@(negedge sclk) disable iff (!rst_n)
        !sdata_oe |-> sdata); // R5

    AST_LOAD_ONLY_IDLE: assert property (@(negedge sclk) disable iff (!rst_n)
        $rose(drdy) |-> $past(!sdata_oe) && $past(cs_n) && $past(word_vld)); // R7

    AST_READY_CLEARS_AT_END: assert property (@(negedge sclk) disable iff (!rst_n)
        $fell(drdy) |-> $fell(sdata_oe)); // R9
endmodule

bind cs_uart_tx cs_uart_tx_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .word_vld (word_vld),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .drdy     (drdy)
);

// File: tb/cs_uart_tx_tb.sv
`timescale 1ns/1ps
// Directed bench for cs_uart_tx. Inputs change just after the rising edge
// and outputs are sampled there; the design acts on the falling edge.
module cs_uart_tx_tb;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [15:0] word_in = '0;
    logic        word_vld = 1'b0;
    logic        sdata;
    logic        sdata_oe;
    logic        drdy;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 sclk = ~sclk;

    cs_uart_tx u_dut (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .word_in  (word_in),
        .word_vld (word_vld),
        .sdata    (sdata),
        .sdata_oe (sdata_oe),
        .drdy     (drdy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] frame_of(input logic [7:0] b);
        return {2'b11, b, 1'b0};
    endfunction

    task automatic load_word(input logic [15:0] w);
        @(posedge sclk);
        word_in  = w;
        word_vld = 1'b1;
        @(posedge sclk);
        word_vld = 1'b0;
    endtask

    // Request one frame and capture its 11 bits; optionally offer a word mid-frame
    task automatic run_frame(input bit keep_low, input bit inject, input logic [15:0] inj_w,
                             output logic [10:0] bits);
        logic oe_all;
        oe_all = 1'b1;
        @(posedge sclk);
        cs_n = 1'b0;
        for (int i = 0; i < 11; i++) begin
            @(posedge sclk);
            bits[i] = sdata;
            oe_all  = oe_all & sdata_oe;
            if (!keep_low) cs_n = 1'b1;
            if (inject && i == 4) begin
                word_in  = inj_w;
                word_vld = 1'b1;
            end else begin
                word_vld = 1'b0;
            end
        end
        @(posedge sclk);
        word_vld = 1'b0;
        check("R2 oe high for whole frame", 32'(oe_all), 32'd1);
        check("R5 oe low after frame", 32'(sdata_oe), 32'd0);
        check("R5 line rests high", 32'(sdata), 32'd1);
    endtask

    task automatic watch_idle(input int n, input string req);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge sclk);
            seen = seen | sdata_oe;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        @(posedge sclk);
        check("R1 oe after reset", 32'(sdata_oe), 32'd0);
        check("R1 sdata after reset", 32'(sdata), 32'd1);
        check("R1 drdy after reset", 32'(drdy), 32'd0);
    endtask

    task automatic t_no_start;
        cs_n = 1'b1;
        watch_idle(20, "R2 no frame while cs_n high");
    endtask

    task automatic t_two_bytes;
        logic [10:0] b;
        load_word(16'hA53C);
        check("R9 drdy set on load", 32'(drdy), 32'd1);
        run_frame(1'b0, 1'b0, '0, b);
        check("R3 R4 upper byte frame", 32'(b), 32'(frame_of(8'hA5)));
        check("R9 drdy held after upper", 32'(drdy), 32'd1);
        run_frame(1'b0, 1'b0, '0, b);
        check("R4 lower byte frame", 32'(b), 32'(frame_of(8'h3C)));
        check("R9 drdy cleared after lower", 32'(drdy), 32'd0);
        run_frame(1'b0, 1'b0, '0, b);
        check("R4 pointer wraps to upper", 32'(b), 32'(frame_of(8'hA5)));
    endtask

    task automatic t_hold_low;
        logic [10:0] b;
        load_word(16'h1234);
        run_frame(1'b1, 1'b0, '0, b);
        check("R3 upper of 1234", 32'(b), 32'(frame_of(8'h12)));
        watch_idle(8, "R6 no frame while cs_n held low");
        load_word(16'hFFFF);
        watch_idle(4, "R6 still no frame");
        @(posedge sclk);
        cs_n = 1'b1;
        @(posedge sclk);
        @(posedge sclk);
        run_frame(1'b0, 1'b0, '0, b);
        check("R7 word ignored while cs_n low", 32'(b), 32'(frame_of(8'h34)));
        check("R9 drdy clear", 32'(drdy), 32'd0);
    endtask

    task automatic t_mid_frame;
        logic [10:0] b;
        load_word(16'h00F0);
        run_frame(1'b0, 1'b1, 16'h5555, b);
        check("R3 upper of 00F0", 32'(b), 32'(frame_of(8'h00)));
        run_frame(1'b0, 1'b0, '0, b);
        check("R7 word ignored during frame", 32'(b), 32'(frame_of(8'hF0)));
    endtask

    task automatic t_replace;
        logic [10:0] b;
        load_word(16'hC3A1);
        run_frame(1'b0, 1'b0, '0, b);
        check("R4 upper of C3A1", 32'(b), 32'(frame_of(8'hC3)));
        load_word(16'h7E81);
        check("R9 drdy after replace", 32'(drdy), 32'd1);
        run_frame(1'b0, 1'b0, '0, b);
        check("R8 new word restarts at upper", 32'(b), 32'(frame_of(8'h7E)));
        run_frame(1'b0, 1'b0, '0, b);
        check("R8 then lower of new word", 32'(b), 32'(frame_of(8'h81)));
    endtask

    initial begin
        repeat (3) @(posedge sclk);
        rst_n = 1'b1;
        t_reset();
        t_no_start();
        t_two_bytes();
        t_hold_low();
        t_mid_frame();
        t_replace();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge sclk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule